// File: doc/BRIEF.md
# D-PHY Configuration Sequencer

This block turns a lane bit rate (in Mbps) and two PLL divider values into the fixed, ordered series of (code, data) byte pairs that set up a D-PHY through its test-port writer. From the rate it picks a PLL parameter set (charge-pump current, loop-filter resistor and frequency-range code) out of an internal rate table. It also derives the VCO range select, encodes both dividers, emits fixed bias and termination words, and computes the eleven lane timing words from nanosecond targets.

A controller presents the rate and dividers and pulses `start`. The block computes the nine distinct timing counts one after another on a serial divider. It then offers the 25 writes one at a time on a valid/ready port, holding each one until the writer accepts it. A `done` pulse marks the end of a sequence. A rate beyond the table's top raises `err` and produces no writes.

Top module: `dphy_cfg_seq`

## Requirements
- R1: After reset, `wr_valid`, `busy`, `done` and `err` are all low.
- R2: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_code`/`wr_data` stay unchanged on the next cycle. A write is taken on each clock edge where both are high.
- R3: A started sequence issues exactly 25 writes, with codes in this order: 10, 11, 12, 44, 17, 18, 19, 18, 19, 22, 22, 20, 21, 21, 60, 61, 62, 63, 64, 65, 70, 71, 72, 73, 74 (hex).
- R4: The write to code 10 carries bit 7 = 1, bit 6 = 0, bits 5:3 = the VCO range, bits 2:1 = 01 and bit 0 = 1. The VCO range is 0 for rates below 200; otherwise it is the low 3 bits of floor((rate+100)/200).
- R5: The rate selects the first table entry whose upper rate bound is at least the rate. Code 11 receives the 4-bit charge-pump code. Code 12 receives C0 hex OR the 6-bit loop-filter code. Code 44 receives the 6-bit frequency-range code shifted left by one.
- R6: Code 17 receives (in_div-1) mod 128. The first code-18 write carries (fb-1) bits 4:0 with bit 7 clear. The second carries (fb-1) bits 8:5 with bit 7 set. Each code-18 write is followed by code 19 with data 30 hex. `fb_div` is taken modulo 512, so 512 is presented as 0.
- R7: Fixed analog words are emitted in this order: code 22 with 07, code 22 with 87, code 20 with 4D, code 21 with 3D, code 21 with DF (hex).
- R8: A byte-clock count for a target of ns nanoseconds is ceil(floor(ns*rate/8)/1000). A UI count is ceil(ns*rate/1000).
- R9: Timing words, as enable OR value, truncated to 8 bits, are: 60 = 80|B(500), 61 = 80|U(40), 62 = 40|B(300), 63 = 80|U(100), 64 = 20|B(100), 65 = 20|(B(60)+7), 70 = 80|B(500), 71 = 80|(U(50)+20), 72 = 40|(B(140)+2), 73 = 80|(U(60)+8), 74 = 20|B(100).
- R10: A start with a rate above 1500 issues no write, sets `err` high and pulses `done`. `err` holds until the next accepted start.
- R11: `done` is high for exactly one cycle after the last write is accepted. After a valid sequence `err` is low.
- R12: A `start` pulse while `busy` is high is ignored. The sequence in progress continues with its original inputs.
- R13: Rates equal to a table bound (89, 1500) select that entry. One above a bound (90) selects the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (sampled when idle) |
| rate_mbps | input | 11 | Lane bit rate in Mbps |
| in_div | input | 7 | PLL input divider value |
| fb_div | input | 9 | PLL feedback divider value, modulo 512 |
| wr_valid | output | 1 | A write is offered |
| wr_ready | input | 1 | The test-port writer accepts the offered write |
| wr_code | output | 8 | Test code of the offered write |
| wr_data | output | 8 | Data byte of the offered write |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last start had an out-of-range rate |

## Verification
The bench targets the rate-table edges (89 against 90, and 1500 against 1501 and beyond). A comparison off by one there would load the neighbouring parameter set or reject a legal rate. A divider of 512 and an input divider of 1 probe the wrap in the divider encodings; a wrong slice would put stray bits into the high loop-divider write. Rates are chosen so the byte-clock and UI rounding each land both on and off integer results, which exposes a floor in place of a ceiling or a wrong offset. A randomly stalling writer and `start` pulses during both the computation and issue phases expose a payload that shifts under backpressure and a sequencer that restarts when it should not.

// File: rtl/dphy_cfg_pkg.sv
package dphy_cfg_pkg;

    localparam int RATE_W   = 11;
    localparam int IDIV_W   = 7;
    localparam int FDIV_W   = 9;
    localparam int BYTE_W   = 8;
    localparam int MAX_RATE = 1500;
    localparam int N_ENTRY  = 39;
    localparam int N_TIME   = 9;
    localparam int TIME_W   = 8;
    localparam int N_WR     = 25;
    localparam int NS_W     = 9;
    localparam int PROD_W   = NS_W + RATE_W;
    localparam int TK_W     = $clog2(N_TIME);
    localparam int WI_W     = $clog2(N_WR);
    localparam int NS_DEN   = 1000;

    typedef struct packed {
        logic [5:0] hs;
        logic [3:0] icp;
        logic [5:0] lpf;
    } pll_sel_t;

    typedef struct packed {
        logic [RATE_W-1:0] top;
        pll_sel_t          sel;
    } rate_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_WAIT,
        ST_ISSUE,
        ST_FIN
    } seq_state_t;

    typedef logic [N_TIME-1:0][TIME_W-1:0] tvec_t;

    function automatic rate_entry_t mk_entry(input int top, input int hs,
                                             input int icp, input int lpf);
        rate_entry_t e;
        e.top     = RATE_W'(top);
        e.sel.hs  = 6'(hs);
        e.sel.icp = 4'(icp);
        e.sel.lpf = 6'(lpf);
        return e;
    endfunction

    // Rate bands, ascending; first band whose bound covers the rate wins.
    function automatic rate_entry_t rate_entry(input int idx);
        case (idx)
            0:  return mk_entry(89,   'h00, 'h1, 'h02);
            1:  return mk_entry(99,   'h10, 'h1, 'h02);
            2:  return mk_entry(109,  'h20, 'h1, 'h02);
            3:  return mk_entry(129,  'h01, 'h1, 'h01);
            4:  return mk_entry(139,  'h11, 'h1, 'h01);
            5:  return mk_entry(149,  'h21, 'h1, 'h01);
            6:  return mk_entry(169,  'h02, 'h9, 'h02);
            7:  return mk_entry(179,  'h12, 'h9, 'h02);
            8:  return mk_entry(199,  'h22, 'h9, 'h02);
            9:  return mk_entry(219,  'h03, 'h2, 'h02);
            10: return mk_entry(239,  'h13, 'h2, 'h02);
            11: return mk_entry(249,  'h23, 'h2, 'h02);
            12: return mk_entry(269,  'h04, 'h9, 'h04);
            13: return mk_entry(299,  'h14, 'h9, 'h04);
            14: return mk_entry(329,  'h05, 'h1, 'h01);
            15: return mk_entry(359,  'h15, 'h1, 'h01);
            16: return mk_entry(399,  'h25, 'h1, 'h01);
            17: return mk_entry(449,  'h06, 'h6, 'h04);
            18: return mk_entry(499,  'h16, 'h6, 'h04);
            19: return mk_entry(549,  'h07, 'h6, 'h08);
            20: return mk_entry(599,  'h17, 'h6, 'h08);
            21: return mk_entry(649,  'h08, 'h6, 'h04);
            22: return mk_entry(699,  'h18, 'h6, 'h04);
            23: return mk_entry(749,  'h09, 'h6, 'h04);
            24: return mk_entry(799,  'h19, 'h6, 'h04);
            25: return mk_entry(849,  'h29, 'h6, 'h04);
            26: return mk_entry(899,  'h39, 'h6, 'h04);
            27: return mk_entry(949,  'h0a, 'hb, 'h10);
            28: return mk_entry(999,  'h1a, 'hb, 'h10);
            29: return mk_entry(1049, 'h2a, 'hb, 'h10);
            30: return mk_entry(1099, 'h3a, 'hb, 'h10);
            31: return mk_entry(1149, 'h0b, 'hb, 'h08);
            32: return mk_entry(1199, 'h1b, 'hb, 'h08);
            33: return mk_entry(1249, 'h2b, 'hb, 'h08);
            34: return mk_entry(1299, 'h3b, 'hb, 'h08);
            35: return mk_entry(1349, 'h0c, 'hb, 'h08);
            36: return mk_entry(1399, 'h1c, 'hb, 'h08);
            37: return mk_entry(1449, 'h2c, 'hb, 'h08);
            38: return mk_entry(MAX_RATE, 'h3c, 'hb, 'h08);
            default: return mk_entry(0, 0, 0, 0);
        endcase
    endfunction

    // Nanosecond target of each computed timing count.
    function automatic logic [NS_W-1:0] step_ns(input logic [TK_W-1:0] k);
        case (k)
            4'd0:    return 9'd500;
            4'd1:    return 9'd40;
            4'd2:    return 9'd300;
            4'd3:    return 9'd100;
            4'd4:    return 9'd100;
            4'd5:    return 9'd60;
            4'd6:    return 9'd50;
            4'd7:    return 9'd140;
            4'd8:    return 9'd60;
            default: return 9'd0;
        endcase
    endfunction

    // 1: count in byte clocks (eight UI each); 0: count in UI.
    function automatic logic step_bytes(input logic [TK_W-1:0] k);
        return (k == 4'd0) || (k == 4'd2) || (k == 4'd4) ||
               (k == 4'd5) || (k == 4'd7);
    endfunction

    function automatic logic [2:0] vco_range(input logic [RATE_W-1:0] r);
        if (r < RATE_W'(200))
            return 3'd0;
        return 3'(({1'b0, r} + 12'd100) / 12'd200);
    endfunction

endpackage

// File: rtl/dphy_rate_lut.sv
module dphy_rate_lut
    import dphy_cfg_pkg::*;
(
    input  logic [RATE_W-1:0] rate,
    output pll_sel_t          sel,
    output logic              hit
);

    logic [N_ENTRY-1:0] covers;

    generate
        for (genvar g = 0; g < N_ENTRY; g++) begin : g_band
            localparam rate_entry_t ENT = rate_entry(g);
            assign covers[g] = (rate <= ENT.top);
        end
    endgenerate

    always_comb begin
        rate_entry_t ent;
        sel = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            ent = rate_entry(i);
            if (covers[i])
                sel = ent.sel;
        end
    end

    assign hit = covers[N_ENTRY-1];

endmodule

// File: rtl/dphy_ceil_div.sv
module dphy_ceil_div #(
    parameter int NUM_W = 20,
    parameter int DEN   = 1000,
    parameter int Q_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    output logic             done,
    output logic [Q_W-1:0]   quot
);

    localparam int RW = $clog2(DEN) + 1;
    localparam int CW = $clog2(NUM_W + 1);

    logic [RW-1:0]    rem;
    logic [RW-1:0]    trial;
    logic [NUM_W-1:0] sh;
    logic [Q_W-1:0]   q;
    logic [CW-1:0]    cnt;
    logic             run;

    assign trial = {rem[RW-2:0], sh[NUM_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            sh   <= '0;
            q    <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !run) begin
                sh  <= num;
                rem <= '0;
                q   <= '0;
                cnt <= CW'(NUM_W);
                run <= 1'b1;
            end else if (run) begin
                if (trial >= RW'(DEN)) begin
                    rem <= trial - RW'(DEN);
                    q   <= {q[Q_W-2:0], 1'b1};
                end else begin
                    rem <= trial;
                    q   <= {q[Q_W-2:0], 1'b0};
                end
                sh  <= sh << 1;
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Round up when a remainder is left; only the low Q_W bits are kept.
    assign quot = q + Q_W'(rem != '0);

endmodule

// File: rtl/dphy_wr_compose.sv
module dphy_wr_compose
    import dphy_cfg_pkg::*;
(
    input  logic [WI_W-1:0]   idx,
    input  logic [2:0]        vco,
    input  pll_sel_t          sel,
    input  logic [IDIV_W-1:0] idiv,
    input  logic [FDIV_W-1:0] fdiv,
    input  tvec_t             tval,
    output logic [BYTE_W-1:0] code,
    output logic [BYTE_W-1:0] data
);

    logic [IDIV_W-1:0] idm1;
    logic [FDIV_W-1:0] fdm1;

    always_comb begin
        idm1 = idiv - IDIV_W'(1);
        fdm1 = fdiv - FDIV_W'(1);
        code = '0;
        data = '0;
        case (idx)
            5'd0:  begin code = 8'h10; data = {1'b1, 1'b0, vco, 2'b01, 1'b1}; end
            5'd1:  begin code = 8'h11; data = {4'h0, sel.icp}; end
            5'd2:  begin code = 8'h12; data = 8'hC0 | {2'b00, sel.lpf}; end
            5'd3:  begin code = 8'h44; data = {1'b0, sel.hs, 1'b0}; end
            5'd4:  begin code = 8'h17; data = {1'b0, idm1}; end
            5'd5:  begin code = 8'h18; data = {3'b000, fdm1[4:0]}; end
            5'd6:  begin code = 8'h19; data = 8'h30; end
            5'd7:  begin code = 8'h18; data = {4'b1000, fdm1[8:5]}; end
            5'd8:  begin code = 8'h19; data = 8'h30; end
            5'd9:  begin code = 8'h22; data = 8'h07; end
            5'd10: begin code = 8'h22; data = 8'h87; end
            5'd11: begin code = 8'h20; data = 8'h4D; end
            5'd12: begin code = 8'h21; data = 8'h3D; end
            5'd13: begin code = 8'h21; data = 8'hDF; end
            5'd14: begin code = 8'h60; data = 8'h80 | tval[0]; end
            5'd15: begin code = 8'h61; data = 8'h80 | tval[1]; end
            5'd16: begin code = 8'h62; data = 8'h40 | tval[2]; end
            5'd17: begin code = 8'h63; data = 8'h80 | tval[3]; end
            5'd18: begin code = 8'h64; data = 8'h20 | tval[4]; end
            5'd19: begin code = 8'h65; data = 8'h20 | (tval[5] + 8'd7); end
            5'd20: begin code = 8'h70; data = 8'h80 | tval[0]; end
            5'd21: begin code = 8'h71; data = 8'h80 | (tval[6] + 8'd20); end
            5'd22: begin code = 8'h72; data = 8'h40 | (tval[7] + 8'd2); end
            5'd23: begin code = 8'h73; data = 8'h80 | (tval[8] + 8'd8); end
            5'd24: begin code = 8'h74; data = 8'h20 | tval[4]; end
            default: begin code = '0; data = '0; end
        endcase
    end

endmodule

// File: rtl/dphy_cfg_seq.sv
module dphy_cfg_seq
    import dphy_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RATE_W-1:0] rate_mbps,
    input  logic [IDIV_W-1:0] in_div,
    input  logic [FDIV_W-1:0] fb_div,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [BYTE_W-1:0] wr_code,
    output logic [BYTE_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              err
);

    seq_state_t        state;
    logic [RATE_W-1:0] rate_q;
    logic [IDIV_W-1:0] idiv_q;
    logic [FDIV_W-1:0] fdiv_q;
    pll_sel_t          sel_q;
    logic [2:0]        vco_q;
    logic [TK_W-1:0]   tk;
    logic [WI_W-1:0]   wi;
    tvec_t             tval;
    logic              err_q;

    pll_sel_t          lut_sel;
    logic              lut_hit;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] div_num;
    logic              div_done;
    logic [TIME_W-1:0] div_q;

    dphy_rate_lut u_lut (
        .rate (rate_mbps),
        .sel  (lut_sel),
        .hit  (lut_hit)
    );

    assign prod    = PROD_W'(step_ns(tk)) * PROD_W'(rate_q);
    assign div_num = step_bytes(tk) ? (prod >> 3) : prod;

    dphy_ceil_div #(
        .NUM_W (PROD_W),
        .DEN   (NS_DEN),
        .Q_W   (TIME_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (state == ST_CALC),
        .num   (div_num),
        .done  (div_done),
        .quot  (div_q)
    );

    dphy_wr_compose u_comp (
        .idx  (wi),
        .vco  (vco_q),
        .sel  (sel_q),
        .idiv (idiv_q),
        .fdiv (fdiv_q),
        .tval (tval),
        .code (wr_code),
        .data (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            rate_q <= '0;
            idiv_q <= '0;
            fdiv_q <= '0;
            sel_q  <= '0;
            vco_q  <= '0;
            tk     <= '0;
            wi     <= '0;
            tval   <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rate_q <= rate_mbps;
                        idiv_q <= in_div;
                        fdiv_q <= fb_div;
                        sel_q  <= lut_sel;
                        vco_q  <= vco_range(rate_mbps);
                        tk     <= '0;
                        wi     <= '0;
                        if (lut_hit) begin
                            err_q <= 1'b0;
                            state <= ST_CALC;
                        end else begin
                            err_q <= 1'b1;
                            state <= ST_FIN;
                        end
                    end
                end
                ST_CALC: state <= ST_WAIT;
                ST_WAIT: begin
                    if (div_done) begin
                        tval[tk] <= div_q;
                        if (tk == TK_W'(N_TIME - 1)) begin
                            state <= ST_ISSUE;
                        end else begin
                            tk    <= tk + TK_W'(1);
                            state <= ST_CALC;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (wr_ready) begin
                        if (wi == WI_W'(N_WR - 1))
                            state <= ST_FIN;
                        else
                            wi <= wi + WI_W'(1);
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_valid = (state == ST_ISSUE);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign err      = err_q;

endmodule

// File: rtl/dphy_cfg_seq_chk.sv
module dphy_cfg_seq_chk
    import dphy_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [BYTE_W-1:0] wr_code,
    input logic [BYTE_W-1:0] wr_data,
    input logic              busy,
    input logic              done,
    input logic              err
);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!wr_valid && !busy && !done && !err));

    // R2
    a_r2_hold_payload: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_code) && $stable(wr_data)));

    // R4
    a_r4_vco_frame: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_code == 8'h10) |->
            (wr_data[7] && !wr_data[6] && wr_data[2:0] == 3'b011));

    // R6
    a_r6_ctl_word: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_code == 8'h19) |-> (wr_data == 8'h30));

    // R10
    a_r10_err_silent: assert property (@(posedge clk) disable iff (rst)
        err |-> !wr_valid);

    // R11
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!wr_valid && busy));

endmodule

bind dphy_cfg_seq dphy_cfg_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_code  (wr_code),
    .wr_data  (wr_data),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/dphy_cfg_seq_bench.sv
module dphy_cfg_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] rate_mbps = '0;
    logic [6:0]  in_div = '0;
    logic [8:0]  fb_div = '0;
    logic        wr_ready = 1'b0;
    logic        wr_valid;
    logic [7:0]  wr_code;
    logic [7:0]  wr_data;
    logic        busy;
    logic        done;
    logic        err;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          done_cnt = 0;
    int          wr_cnt = 0;
    logic [15:0] exp_q[$];
    logic [7:0]  lf = 8'hA5;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    dphy_cfg_seq u_dphy_cfg_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rate_mbps (rate_mbps),
        .in_div    (in_div),
        .fb_div    (fb_div),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_code   (wr_code),
        .wr_data   (wr_data),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] c);
        if (c == 8'h10) return "R4";
        if (c == 8'h11 || c == 8'h12 || c == 8'h44) return "R5/R13";
        if (c == 8'h17 || c == 8'h18 || c == 8'h19) return "R6";
        if (c == 8'h20 || c == 8'h21 || c == 8'h22) return "R7";
        return "R8/R9";
    endfunction

    function automatic int bcn(input int ns, input int r);
        return (((ns * r) / 8) + 999) / 1000;
    endfunction

    function automatic int uin(input int ns, input int r);
        return ((ns * r) + 999) / 1000;
    endfunction

    task automatic push(input int c, input int d);
        exp_q.push_back({8'(c), 8'(d & 255)});
    endtask

    // Monitor: choose ready for the coming edge, then score any transfer.
    always @(negedge clk) begin
        if (!rst) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            wr_ready = lf[0] | lf[3];
            if (wr_valid && wr_ready) begin
                wr_cnt++;
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R3/R10/R12 extra write: actual code %h expected none", wr_code);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    n_cmp++;
                    if (wr_code != e[15:8]) begin
                        n_bad++;
                        $display("FAIL R3 code: actual %h expected %h", wr_code, e[15:8]);
                    end else if (wr_data != e[7:0]) begin
                        n_bad++;
                        $display("FAIL %s data at code %h: actual %h expected %h",
                                 req_of(wr_code), wr_code, wr_data, e[7:0]);
                    end
                end
            end
            if (done) done_cnt++;
        end
    end

    task automatic expect_seq(input int r, input int id, input int fb,
                              input int hs, input int icp, input int lpf);
        int v;
        v = (r < 200) ? 0 : ((r + 100) / 200) % 8;
        push('h10, 128 | (v << 3) | 2 | 1);
        push('h11, icp);
        push('h12, 'hC0 | lpf);
        push('h44, hs << 1);
        push('h17, (id - 1) & 127);
        push('h18, (fb - 1) & 31);
        push('h19, 'h30);
        push('h18, 128 | (((fb - 1) >> 5) & 15));
        push('h19, 'h30);
        push('h22, 'h07);
        push('h22, 'h87);
        push('h20, 'h4D);
        push('h21, 'h3D);
        push('h21, 'hDF);
        push('h60, 128 | bcn(500, r));
        push('h61, 128 | uin(40, r));
        push('h62, 64 | bcn(300, r));
        push('h63, 128 | uin(100, r));
        push('h64, 32 | bcn(100, r));
        push('h65, 32 | ((bcn(60, r) + 7) & 255));
        push('h70, 128 | bcn(500, r));
        push('h71, 128 | ((uin(50, r) + 20) & 255));
        push('h72, 64 | ((bcn(140, r) + 2) & 255));
        push('h73, 128 | ((uin(60, r) + 8) & 255));
        push('h74, 32 | bcn(100, r));
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt == d0) @(negedge clk);
    endtask

    task automatic run_cfg(input int r, input int id, input int fb, input int hs,
                           input int icp, input int lpf, input int poke);
        int d0;
        d0 = done_cnt;
        expect_seq(r, id, fb, hs, icp, lpf);
        @(negedge clk);
        rate_mbps = 11'(r);
        in_div    = 7'(id);
        fb_div    = 9'(fb);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            chk(busy == 1'b1, "R12", "busy at second start", int'(busy), 1);
            rate_mbps = 11'd300;
            in_div    = 7'd3;
            fb_div    = 9'd100;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(d0);
        chk(exp_q.size() == 0, "R3/R11", "writes left at done", exp_q.size(), 0);
        chk(err == 1'b0, "R11", "err after valid run", int'(err), 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R11", "done pulses", done_cnt - d0, 1);
        chk(busy == 1'b0, "R11", "busy after done", int'(busy), 0);
        exp_q.delete();
    endtask

    task automatic run_err(input int r);
        int d0;
        int w0;
        d0 = done_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        rate_mbps = 11'(r);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(d0);
        @(negedge clk);
        chk(err == 1'b1, "R10", "err for out-of-range rate", int'(err), 1);
        repeat (30) @(negedge clk);
        chk(wr_cnt == w0, "R10", "writes after bad rate", wr_cnt - w0, 0);
        chk(err == 1'b1, "R10", "err held", int'(err), 1);
        chk(done_cnt == d0 + 1, "R10", "done pulses", done_cnt - d0, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_valid == 1'b0, "R1", "wr_valid after reset", int'(wr_valid), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(err == 1'b0, "R1", "err after reset", int'(err), 0);

        // R13 lower band edge and the band above it
        run_cfg(89, 2, 40, 'h00, 'h1, 'h02, 0);
        run_cfg(90, 3, 36, 'h10, 'h1, 'h02, 0);
        // R5 band change in the middle of the table
        run_cfg(150, 4, 60, 'h02, 'h9, 'h02, 0);
        // R4 first nonzero VCO range
        run_cfg(200, 1, 80, 'h03, 'h2, 'h02, 0);
        // R8 rounding on a non-round rate; R12 start during computation
        run_cfg(481, 5, 100, 'h16, 'h6, 'h04, 5);
        // R12 start during issue
        run_cfg(1000, 6, 250, 'h2a, 'hb, 'h10, 230);
        // R13 top edge; R6 divider 512 and input divider 127
        run_cfg(1500, 127, 512, 'h3c, 'hb, 'h08, 0);
        // R10 just above the top and far above it
        run_err(1501);
        run_err(2047);
        // R11 err clears on the next good start
        run_cfg(733, 2, 146, 'h09, 'h6, 'h04, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule